// File: doc/BRIEF.md
# Unsigned Compare-and-Skip Execution Unit

This unit carries out the two unsigned compare-and-skip instructions of a small 8-bit accumulator core. An instruction word arrives with a `start` strobe together with the working register and the bank select value. The unit first forms a 12-bit data-memory address from the 8-bit register field, the bank-override bit and the bank select value. It reads the addressed byte through a synchronous read port and compares that byte with the working register by unsigned subtraction.

Each instruction cycle is four clocks long, one clock per quarter phase. In the first phase the word is decoded. In the second the read is issued. In the third the byte is compared. The fourth phase does nothing. When the skip condition holds, the unit tells the fetch stage to replace the prefetched instruction with no-operation cycles. The fetch stage reports whether that prefetched instruction is two words long, and the unit then inserts two no-operation cycles instead of one. Each inserted cycle spans four idle phases. A one-clock `done` pulse marks the end of the last cycle. No flag or register is written by this unit.

Top module: `cmpskip_unit`

## Requirements
- R1: Opcode bits [15:9] = 7'b0110010 request a skip exactly when the addressed byte is greater than W. When the byte equals W, no flush is raised.
- R2: Opcode bits [15:9] = 7'b0110000 request a skip exactly when the addressed byte is less than W. When the byte equals W, no flush is raised.
- R3: The comparison treats both operands as unsigned 8-bit values. For example, 0x80 is greater than 0x7F.
- R4: When bit 8 is 0, the register field (bits [7:0]) below 0x80 addresses bank 0 and the field at 0x80 or above addresses bank 15. The bank select input is ignored in this mode.
- R5: When bit 8 is 1, the address is {bank_sel[3:0], bits [7:0]}.
- R6: `qphase` steps 0,1,2,3 through the instruction cycle. `mem_rd_en` is high for exactly one clock, during phase 1 of the instruction cycle, with `mem_addr` valid. Memory data is expected one clock later.
- R7: On a skip, `flush_req` pulses for one clock at the end of phase 3. `flush_count` is 1, or 2 when `next_two_word` is high at that time. `nop_cycle` stays high for 4 clocks per inserted cycle.
- R8: The number of clock edges from the one that accepts `start` to the one that raises `done` is 4 without a skip, 8 for a one-word skip and 12 for a two-word skip. `done` is a one-clock pulse.
- R9: A `start` with any other opcode is ignored: `busy`, `mem_rd_en`, `flush_req` and `done` all stay low.
- R10: A `start` while `busy` is high is ignored. The running instruction completes with its own operands, and no second instruction follows.
- R11: After synchronous reset, `busy`, `mem_rd_en`, `flush_req`, `flush_count`, `done`, `nop_cycle` and `qphase` are all zero. Reset aborts an instruction in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one quarter phase per edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Instruction word valid |
| instr_word | input | 16 | Instruction word |
| w_reg | input | 8 | Working register value |
| bank_sel | input | 4 | Bank select register |
| mem_addr | output | 12 | Data-memory read address |
| mem_rd_en | output | 1 | Read strobe (phase 1) |
| mem_rd_data | input | 8 | Read data, valid one clock after the strobe |
| next_two_word | input | 1 | Prefetched instruction is two words |
| flush_req | output | 1 | Discard prefetched instruction |
| flush_count | output | 2 | Number of no-operation cycles to insert |
| done | output | 1 | Final cycle finished |
| busy | output | 1 | Instruction in progress |
| qphase | output | 2 | Current quarter phase |
| nop_cycle | output | 1 | Inside an inserted no-operation cycle |

## Verification
The bench builds the unit with its default parameters: an 8-bit datapath, an 8-bit register field, a 4-bit bank select, the access-bank split at 0x80 and the upper access bank at 15. With these values both halves of the access bank, every bank select value, and the unsigned boundary around 0x7F/0x80 can all be reached. So can the equality case, the extremes 0x00 and 0xFF, and both flush lengths. The bench computes each expected address and memory byte from an address-derived memory function that is independent of the design.

// File: rtl/cmpskip_pkg.sv
package cmpskip_pkg;
  localparam int OPC_W = 7;
  localparam logic [OPC_W-1:0] OPC_SKIP_GT = 7'b0110010;
  localparam logic [OPC_W-1:0] OPC_SKIP_LT = 7'b0110000;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EXEC = 2'd1,
    ST_SKIP = 2'd2
  } seq_state_t;

  typedef enum logic {
    CMP_LT = 1'b0,
    CMP_GT = 1'b1
  } cmp_kind_t;
endpackage

// File: rtl/cmpskip_decode.sv
module cmpskip_decode
  import cmpskip_pkg::*;
#(
  parameter int INSTR_W      = 16,
  parameter int F_W          = 8,
  parameter int BANK_W       = 4,
  parameter int ACCESS_SPLIT = 128,
  parameter int HIGH_BANK    = 15,
  localparam int ADDR_W      = F_W + BANK_W
) (
  input  logic [INSTR_W-1:0] word,
  input  logic [BANK_W-1:0]  bank,
  output logic               valid,
  output cmp_kind_t          kind,
  output logic [ADDR_W-1:0]  addr
);
  localparam int A_BIT = F_W;
  localparam logic [BANK_W-1:0] HIGH_B = BANK_W'(HIGH_BANK);
  localparam logic [F_W-1:0] SPLIT = F_W'(ACCESS_SPLIT);

  logic [OPC_W-1:0] opc;
  logic [F_W-1:0]   freg;
  logic             banked;
  logic [BANK_W-1:0] eff_bank;

  assign opc    = word[INSTR_W-1:A_BIT+1];
  assign banked = word[A_BIT];
  assign freg   = word[F_W-1:0];

  always_comb begin
    valid = 1'b0;
    kind  = CMP_LT;
    if (opc == OPC_SKIP_GT) begin
      valid = 1'b1;
      kind  = CMP_GT;
    end else if (opc == OPC_SKIP_LT) begin
      valid = 1'b1;
      kind  = CMP_LT;
    end
  end

  always_comb begin
    if (banked)
      eff_bank = bank;
    else if (freg >= SPLIT)
      eff_bank = HIGH_B;
    else
      eff_bank = '0;
  end

  assign addr = {eff_bank, freg};
endmodule

// File: rtl/cmpskip_compare.sv
module cmpskip_compare
  import cmpskip_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  cmp_kind_t         kind,
  input  logic [DATA_W-1:0] fval,
  input  logic [DATA_W-1:0] wval,
  output logic              take_skip
);
  logic [DATA_W:0] diff;
  logic            borrow;
  logic            is_zero;
  logic            cond;

  assign diff    = {1'b0, fval} - {1'b0, wval};
  assign borrow  = diff[DATA_W];
  assign is_zero = (diff[DATA_W-1:0] == '0);

  always_comb begin
    if (kind == CMP_GT)
      cond = !borrow && !is_zero;
    else
      cond = borrow;
  end

  always_ff @(posedge clk) begin
    if (rst)
      take_skip <= 1'b0;
    else if (capture)
      take_skip <= cond;
  end
endmodule

// File: rtl/cmpskip_seq.sv
module cmpskip_seq
  import cmpskip_pkg::*;
#(
  parameter int PHASES = 4,
  parameter int MAX_NOPS = 2,
  localparam int PH_W  = $clog2(PHASES),
  localparam int CNT_W = $clog2(MAX_NOPS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  input  logic             take_skip,
  input  logic             two_word,
  output logic             busy,
  output logic [PH_W-1:0]  phase,
  output logic             in_exec,
  output logic             nop_cycle,
  output logic             flush_req,
  output logic [CNT_W-1:0] flush_count,
  output logic             done
);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(PHASES - 1);

  seq_state_t       state;
  logic [CNT_W-1:0] nops_left;
  logic             last_phase;

  assign last_phase = (phase == LAST_PH);
  assign busy       = (state != ST_IDLE);
  assign in_exec    = (state == ST_EXEC);
  assign nop_cycle  = (state == ST_SKIP);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      phase       <= '0;
      nops_left   <= '0;
      flush_req   <= 1'b0;
      flush_count <= '0;
      done        <= 1'b0;
    end else begin
      flush_req <= 1'b0;
      done      <= 1'b0;
      case (state)
        ST_IDLE: begin
          phase <= '0;
          if (launch) state <= ST_EXEC;
        end
        ST_EXEC: begin
          phase <= last_phase ? '0 : phase + 1'b1;
          if (last_phase) begin
            if (take_skip) begin
              state       <= ST_SKIP;
              flush_req   <= 1'b1;
              flush_count <= two_word ? CNT_W'(2) : CNT_W'(1);
              nops_left   <= two_word ? CNT_W'(2) : CNT_W'(1);
            end else begin
              state       <= ST_IDLE;
              flush_count <= '0;
              done        <= 1'b1;
            end
          end
        end
        ST_SKIP: begin
          phase <= last_phase ? '0 : phase + 1'b1;
          if (last_phase) begin
            if (nops_left == CNT_W'(1)) begin
              state       <= ST_IDLE;
              nops_left   <= '0;
              flush_count <= '0;
              done        <= 1'b1;
            end else begin
              nops_left <= nops_left - 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cmpskip_unit.sv
module cmpskip_unit
  import cmpskip_pkg::*;
#(
  parameter int INSTR_W      = 16,
  parameter int DATA_W       = 8,
  parameter int F_W          = 8,
  parameter int BANK_W       = 4,
  parameter int ACCESS_SPLIT = 128,
  parameter int HIGH_BANK    = 15,
  parameter int PHASES       = 4,
  parameter int MAX_NOPS     = 2,
  localparam int ADDR_W      = F_W + BANK_W,
  localparam int PH_W        = $clog2(PHASES),
  localparam int CNT_W       = $clog2(MAX_NOPS + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [INSTR_W-1:0] instr_word,
  input  logic [DATA_W-1:0]  w_reg,
  input  logic [BANK_W-1:0]  bank_sel,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic               mem_rd_en,
  input  logic [DATA_W-1:0]  mem_rd_data,
  input  logic               next_two_word,
  output logic               flush_req,
  output logic [CNT_W-1:0]   flush_count,
  output logic               done,
  output logic               busy,
  output logic [PH_W-1:0]    qphase,
  output logic               nop_cycle
);
  localparam logic [PH_W-1:0] PH_DECODE  = PH_W'(0);
  localparam logic [PH_W-1:0] PH_READ    = PH_W'(1);
  localparam logic [PH_W-1:0] PH_PROCESS = PH_W'(2);

  logic              dec_valid;
  cmp_kind_t         dec_kind;
  logic [ADDR_W-1:0] dec_addr;
  logic              launch;
  logic              in_exec;
  logic              take_skip;

  cmp_kind_t         kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] w_q;

  cmpskip_decode #(
    .INSTR_W(INSTR_W), .F_W(F_W), .BANK_W(BANK_W),
    .ACCESS_SPLIT(ACCESS_SPLIT), .HIGH_BANK(HIGH_BANK)
  ) u_decode (
    .word(instr_word), .bank(bank_sel),
    .valid(dec_valid), .kind(dec_kind), .addr(dec_addr)
  );

  assign launch = start && !busy && dec_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q <= CMP_LT;
      addr_q <= '0;
      w_q    <= '0;
    end else if (launch) begin
      kind_q <= dec_kind;
      addr_q <= dec_addr;
      w_q    <= w_reg;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_rd_en <= 1'b0;
      mem_addr  <= '0;
    end else begin
      mem_rd_en <= in_exec && (qphase == PH_DECODE);
      if (in_exec && (qphase == PH_DECODE))
        mem_addr <= addr_q;
    end
  end

  cmpskip_compare #(.DATA_W(DATA_W)) u_compare (
    .clk(clk), .rst(rst),
    .capture(in_exec && (qphase == PH_PROCESS)),
    .kind(kind_q), .fval(mem_rd_data), .wval(w_q),
    .take_skip(take_skip)
  );

  cmpskip_seq #(.PHASES(PHASES), .MAX_NOPS(MAX_NOPS)) u_seq (
    .clk(clk), .rst(rst), .launch(launch),
    .take_skip(take_skip), .two_word(next_two_word),
    .busy(busy), .phase(qphase), .in_exec(in_exec),
    .nop_cycle(nop_cycle), .flush_req(flush_req),
    .flush_count(flush_count), .done(done)
  );

  logic unused_read_ph;
  assign unused_read_ph = (PH_READ == PH_DECODE);
endmodule

// File: rtl/cmpskip_checker.sv
module cmpskip_checker #(
  parameter int PH_W  = 2,
  parameter int CNT_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic [PH_W-1:0]  qphase,
  input logic             nop_cycle,
  input logic             mem_rd_en,
  input logic             flush_req,
  input logic [CNT_W-1:0] flush_count,
  input logic             done
);
  p_read_in_q2_r6: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> (busy && !nop_cycle && qphase == PH_W'(1)));

  p_read_single_r6: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en);

  p_flush_count_r7: assert property (@(posedge clk) disable iff (rst)
    flush_req |-> (flush_count == CNT_W'(1) || flush_count == CNT_W'(2)));

  p_flush_enters_nop_r7: assert property (@(posedge clk) disable iff (rst)
    flush_req |-> (nop_cycle && qphase == '0));

  p_flush_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    flush_req |=> !flush_req);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_rd_en && !flush_req && !nop_cycle));
endmodule

bind cmpskip_unit cmpskip_checker #(.PH_W(PH_W), .CNT_W(CNT_W)) u_checker (
  .clk(clk), .rst(rst), .busy(busy), .qphase(qphase),
  .nop_cycle(nop_cycle), .mem_rd_en(mem_rd_en), .flush_req(flush_req),
  .flush_count(flush_count), .done(done)
);

// File: tb/cmpskip_unit_bench.sv
module cmpskip_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] instr_word = '0;
  logic [7:0]  w_reg = '0;
  logic [3:0]  bank_sel = '0;
  logic [11:0] mem_addr;
  logic        mem_rd_en;
  logic [7:0]  mem_rd_data;
  logic        next_two_word = 1'b0;
  logic        flush_req;
  logic [1:0]  flush_count;
  logic        done;
  logic        busy;
  logic [1:0]  qphase;
  logic        nop_cycle;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  cmpskip_unit u_cmpskip_unit (
    .clk(clk), .rst(rst), .start(start), .instr_word(instr_word),
    .w_reg(w_reg), .bank_sel(bank_sel), .mem_addr(mem_addr),
    .mem_rd_en(mem_rd_en), .mem_rd_data(mem_rd_data),
    .next_two_word(next_two_word), .flush_req(flush_req),
    .flush_count(flush_count), .done(done), .busy(busy),
    .qphase(qphase), .nop_cycle(nop_cycle)
  );

  function automatic logic [7:0] mem_fn(input logic [11:0] a);
    return a[7:0] ^ {a[11:8], a[11:8]};
  endfunction

  always_ff @(posedge clk)
    if (mem_rd_en) mem_rd_data <= mem_fn(mem_addr);

  task automatic check(input string req, input logic ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // fields: gt, a, f[7:0], bsr[3:0], w[7:0], two
  localparam logic [22:0] VEC [12] = '{
    {1'b1, 1'b0, 8'h10, 4'h3, 8'h05, 1'b0},
    {1'b1, 1'b0, 8'h10, 4'h3, 8'h10, 1'b0},
    {1'b1, 1'b0, 8'h90, 4'h0, 8'h7F, 1'b1},
    {1'b1, 1'b1, 8'h22, 4'h5, 8'hFF, 1'b0},
    {1'b1, 1'b1, 8'h00, 4'h0, 8'h00, 1'b1},
    {1'b0, 1'b0, 8'h7F, 4'h9, 8'h80, 1'b0},
    {1'b0, 1'b0, 8'h80, 4'h2, 8'h7F, 1'b0},
    {1'b0, 1'b1, 8'h44, 4'hA, 8'hEE, 1'b1},
    {1'b0, 1'b1, 8'hFF, 4'hF, 8'h00, 1'b1},
    {1'b0, 1'b1, 8'h31, 4'h7, 8'h46, 1'b0},
    {1'b1, 1'b1, 8'hC3, 4'h1, 8'h10, 1'b1},
    {1'b0, 1'b0, 8'h05, 4'hC, 8'h05, 1'b1}
  };

  task automatic run_instr(input logic gt, input logic a, input logic [7:0] f,
                           input logic [3:0] bsr, input logic [7:0] w, input logic two,
                           input logic poke_busy);
    logic [11:0] exp_addr;
    logic [7:0]  fv;
    logic        skip;
    int          exp_lat, cnt, rd_seen, rd_at, fl_at, fl_cnt, nops;
    logic [11:0] rd_addr;
    if (!a) exp_addr = {(f >= 8'h80) ? 4'hF : 4'h0, f};
    else    exp_addr = {bsr, f};
    fv   = mem_fn(exp_addr);
    skip = gt ? (fv > w) : (fv < w);
    exp_lat = skip ? (two ? 12 : 8) : 4;
    @(negedge clk);
    instr_word = {gt ? 7'b0110010 : 7'b0110000, a, f};
    w_reg = w; bank_sel = bsr; next_two_word = two; start = 1'b1;
    @(negedge clk);
    start = 1'b0; instr_word = 16'hFFFF; w_reg = ~w; bank_sel = ~bsr;
    cnt = 1; rd_seen = 0; rd_at = -1; fl_at = -1; fl_cnt = 0; nops = 0; rd_addr = '0;
    while (!done && cnt < 40) begin
      if (mem_rd_en) begin rd_seen++; rd_at = cnt - 1; rd_addr = mem_addr; end
      if (flush_req) begin fl_at = cnt - 1; fl_cnt = flush_count; end
      if (nop_cycle) nops++;
      if (poke_busy && cnt == 2) begin
        instr_word = {7'b0110000, 1'b1, 8'h00}; w_reg = 8'hFF; start = 1'b1;
      end else start = 1'b0;
      @(negedge clk);
      cnt++;
    end
    start = 1'b0;
    check(a ? "R5 banked address" : "R4 access address", rd_addr == exp_addr, rd_addr, exp_addr);
    check("R6 single read in phase 1", rd_seen == 1 && rd_at == 1, rd_at, 1);
    check(gt ? "R1 greater skip / R3 unsigned" : "R2 less skip / R3 unsigned",
          (fl_at >= 0) == skip, fl_at >= 0, skip);
    if (skip) begin
      check("R7 flush timing and count", fl_at == 4 && fl_cnt == (two ? 2 : 1), fl_cnt, two ? 2 : 1);
      check("R7 nop cycle clocks", nops == (two ? 8 : 4), nops, two ? 8 : 4);
    end
    check("R8 latency", cnt - 1 == exp_lat, cnt - 1, exp_lat);
    @(negedge clk);
    check("R8 done single pulse", !done && !busy, done, 0);
    if (poke_busy) begin
      repeat (6) begin
        check("R10 no second instruction", !busy && !mem_rd_en, busy, 0);
        @(negedge clk);
      end
    end
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        failures++; checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    check("R11 reset outputs", !busy && !mem_rd_en && !flush_req && !done && !nop_cycle
          && flush_count == 0 && qphase == 0, busy, 0);
    rst = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 12; i++)
      run_instr(VEC[i][22], VEC[i][21], VEC[i][20:13], VEC[i][12:9], VEC[i][8:1], VEC[i][0], 1'b0);

    // R9: foreign opcode ignored
    @(negedge clk);
    instr_word = {7'b0110101, 1'b1, 8'h20}; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 8; k++) begin
      check("R9 foreign opcode ignored", !busy && !mem_rd_en && !flush_req && !done, busy, 0);
      @(negedge clk);
    end

    // R10: start while busy (first instruction skips, greater: 0x10 vs 0x05)
    run_instr(1'b1, 1'b0, 8'h10, 4'h3, 8'h05, 1'b1, 1'b1);

    // R11: reset aborts a skip in progress
    @(negedge clk);
    instr_word = {7'b0110010, 1'b0, 8'h10}; w_reg = 8'h00; next_two_word = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    check("R11 in skip before reset", nop_cycle && busy, nop_cycle, 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R11 reset aborts", !busy && !nop_cycle && !done && qphase == 0 && flush_count == 0, busy, 0);
    repeat (10) begin
      @(negedge clk);
      check("R11 stays idle after abort", !busy && !done, done, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule